// File: doc/BRIEF.md
# Successive-Approximation Conversion Sequencer

This block is the digital side of a successive-approximation converter. Software programs a configuration register, which picks the clock source, a power-of-two divider, a short or long sample window and an 8- or 10-bit result. It also programs a control register, which enables the converter and selects software start, hardware-trigger start, continuous repetition and the interrupt. The block derives a conversion clock and runs a sample window. It then resolves the result one bit per conversion clock, MSB first. Each trial code goes out on `dac_code`, and the external comparator returns its decision on `cmp_in`.

When a conversion completes, a done flag is set. If the interrupt is enabled, `irq` rises, and that output doubles as the wake request. The result is read as two bytes. Reading the high byte locks the result until the low byte is read. The block follows the chip power mode. In light stop it keeps converting only when the asynchronous tick is its clock source, and otherwise it drops to idle. Any deep stop mode clears every register.

Top module: `adc_sar_ctrl`

## Requirements
- R1: After reset, the configuration (address 0), control (address 1), result-high (address 2) and result-low (address 3) registers all read 0 and `irq` is 0.
- R2: The configuration byte holds the clock source in bits [1:0] (0 = every clock, 1 = every second clock, 2 = `alt_tick`, 3 = `async_tick`), the divider in [3:2] (ratio 2^value), the long-sample bit in [4], the 10-bit resolution bit in [5] and the low-power bit in [6]; all written fields read back unchanged.
- R3: A conversion spends 4 conversion clocks sampling (20 with the long-sample bit set), then one conversion clock per result bit. At divide-by-1 from the every-clock source, the done flag is visible 14 (10-bit), 12 (8-bit) or 30 (10-bit, long) clocks after the starting write.
- R4: A trial bit is kept when `cmp_in` is 1 while `dac_code` presents it. A 10-bit result reads as {6'b0, result[9:8]} in the high byte and result[7:0] in the low byte. An 8-bit result is the top 8 SAR bits, placed in the low byte, with a high byte of 0.
- R5: The conversion clock fires once every 2^divider source ticks.
- R6: The control byte holds the enable in bit [0] and the hardware-trigger select in bit [4]. A write with enable=1 and trigger-select=0 starts a conversion. With trigger-select=1, a rising `hw_trig` while idle starts one. With enable=0, nothing starts.
- R7: With the continuous bit [5] set, a new sample phase begins right after each completion.
- R8: The done flag is bit [7] of the control byte. `irq` equals done AND the interrupt-enable bit [6]. Done clears on a control write or on a read of the low result byte.
- R9: Reading the high result byte sets a lock. While the lock is set, a completion changes neither the result nor the done flag. A read of the low byte clears the lock.
- R10: A control write during a conversion aborts it and starts again from the sample phase.
- R11: In light stop (`pwr_mode`=1) with the asynchronous source, a conversion in progress finishes, raises `irq` when enabled, and a hardware trigger can start a new conversion.
- R12: In light stop with any other source, a running conversion is abandoned and neither software nor hardware trigger starts one.
- R13: In deep stop (`pwr_mode`[1]=1), every register returns to its reset value and no conversion runs until software reprograms the block.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pwr_mode | input | 2 | 0 run, 1 light stop, 2/3 deep stop |
| alt_tick | input | 1 | Alternate clock-source enable pulse |
| async_tick | input | 1 | Asynchronous local-oscillator enable pulse |
| reg_addr | input | 2 | Register select: 0 config, 1 control, 2 result high, 3 result low |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Write data |
| rd_en | input | 1 | Read strobe (result reads have side effects) |
| rd_data | output | 8 | Read data for `reg_addr` |
| hw_trig | input | 1 | Hardware conversion trigger |
| cmp_in | input | 1 | Comparator decision: 1 when input is at or above `dac_code` |
| dac_code | output | 10 | Trial code during bit resolution, 0 otherwise |
| sampling | output | 1 | High during the sample phase |
| irq | output | 1 | Completion interrupt and wake request |

## Verification
The bench measures the exact start-to-done latency for each sample length and resolution, so a sample counter that is off by one or a wrong stop bit shows up as a shifted count. It locks the result with a high-byte read and then converts again, and a design that ignores the lock would overwrite the old value or set the flag. Light stop is exercised with both the asynchronous and the synchronous source: a design that stops on the first would never wake the system, and one that runs on the second would finish a conversion it should have dropped. Deep stop must leave every register at zero with nothing restarting, and a control write in mid-conversion must restart the full latency count.

// File: rtl/adc_sar_ctrl.sv
`timescale 1ns/1ps
module adc_sar_ctrl #(
  parameter int SHORT_SMP = 4,
  parameter int LONG_SMP  = 20
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] pwr_mode,
  input  logic       alt_tick,
  input  logic       async_tick,
  input  logic [1:0] reg_addr,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  input  logic       rd_en,
  output logic [7:0] rd_data,
  input  logic       hw_trig,
  input  logic       cmp_in,
  output logic [9:0] dac_code,
  output logic       sampling,
  output logic       irq
);
  localparam int RES_W = 10;
  localparam int SMP_W = $clog2(LONG_SMP + 1);

  typedef enum logic [1:0] {IDLE, SAMPLE, CONV} st_t;

  st_t              state;
  logic [1:0]       cfg_src, cfg_div;
  logic             cfg_long, cfg_res10, cfg_lp;
  logic             sc_ie, sc_cont, sc_trg, sc_en, done_q, res_lock;
  logic [RES_W-1:0] res_q, sar_q;
  logic [SMP_W-1:0] smp_cnt;
  logic [3:0]       bit_idx;
  logic [2:0]       div_cnt;
  logic             half_q, trig_q;

  wire deep   = pwr_mode[1];
  wire light  = (pwr_mode == 2'b01);
  wire halted = light && (cfg_src != 2'd3);
  wire sc_wr  = wr_en && (reg_addr == 2'd1);
  wire cfg_wr = wr_en && (reg_addr == 2'd0);
  wire rd_hi  = rd_en && (reg_addr == 2'd2);
  wire rd_lo  = rd_en && (reg_addr == 2'd3);

  logic src_tick;
  always_comb begin
    case (cfg_src)
      2'd0:    src_tick = 1'b1;
      2'd1:    src_tick = half_q;
      2'd2:    src_tick = alt_tick;
      default: src_tick = async_tick;
    endcase
  end

  wire [2:0] dmask     = ~(3'b111 << cfg_div);
  wire       conv_tick = src_tick && ((div_cnt & dmask) == dmask);

  wire [SMP_W-1:0] smp_last = cfg_long ? SMP_W'(LONG_SMP - 1) : SMP_W'(SHORT_SMP - 1);
  wire [3:0]       lsb_idx  = cfg_res10 ? 4'd0 : 4'd2;
  wire [RES_W-1:0] trial    = sar_q | (RES_W'(1) << bit_idx);
  wire [RES_W-1:0] decided  = cmp_in ? trial : sar_q;
  wire [RES_W-1:0] res_val  = cfg_res10 ? decided : {2'b00, decided[RES_W-1:2]};
  wire             finish   = (state == CONV) && conv_tick && (bit_idx <= lsb_idx);

  wire sw_start = sc_wr && wr_data[0] && !wr_data[4] && !halted;
  wire hw_start = sc_en && sc_trg && hw_trig && !trig_q && (state == IDLE) && !halted;

  assign dac_code = (state == CONV) ? trial : '0;
  assign sampling = (state == SAMPLE);
  assign irq      = done_q && sc_ie;

  always_comb begin
    case (reg_addr)
      2'd0:    rd_data = {1'b0, cfg_lp, cfg_res10, cfg_long, cfg_div, cfg_src};
      2'd1:    rd_data = {done_q, sc_ie, sc_cont, sc_trg, 3'b000, sc_en};
      2'd2:    rd_data = {6'b0, res_q[9:8]};
      default: rd_data = res_q[7:0];
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      half_q  <= 1'b0;
      div_cnt <= '0;
      trig_q  <= 1'b0;
    end else begin
      half_q  <= !half_q;
      trig_q  <= hw_trig;
      if (deep)          div_cnt <= '0;
      else if (src_tick) div_cnt <= div_cnt + 3'd1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      {cfg_src, cfg_div, cfg_long, cfg_res10, cfg_lp} <= '0;
      {sc_ie, sc_cont, sc_trg, sc_en, done_q, res_lock} <= '0;
      res_q <= '0; sar_q <= '0; smp_cnt <= '0; bit_idx <= '0;
      state <= IDLE;
    end else if (deep) begin
      {cfg_src, cfg_div, cfg_long, cfg_res10, cfg_lp} <= '0;
      {sc_ie, sc_cont, sc_trg, sc_en, done_q, res_lock} <= '0;
      res_q <= '0; sar_q <= '0; smp_cnt <= '0; bit_idx <= '0;
      state <= IDLE;
    end else begin
      if (cfg_wr) begin
        cfg_src   <= wr_data[1:0];
        cfg_div   <= wr_data[3:2];
        cfg_long  <= wr_data[4];
        cfg_res10 <= wr_data[5];
        cfg_lp    <= wr_data[6];
      end
      if (sc_wr) begin
        sc_en   <= wr_data[0];
        sc_trg  <= wr_data[4];
        sc_cont <= wr_data[5];
        sc_ie   <= wr_data[6];
      end
      if (rd_hi) res_lock <= 1'b1;
      if (rd_lo) res_lock <= 1'b0;
      if (sc_wr || rd_lo) done_q <= 1'b0;
      if (finish && !res_lock) begin
        res_q  <= res_val;
        done_q <= 1'b1;
      end

      if (halted) begin
        state <= IDLE;
      end else if (sc_wr) begin
        state   <= sw_start ? SAMPLE : IDLE;
        smp_cnt <= '0;
      end else if (hw_start) begin
        state   <= SAMPLE;
        smp_cnt <= '0;
      end else begin
        case (state)
          SAMPLE: if (conv_tick) begin
            if (smp_cnt == smp_last) begin
              state   <= CONV;
              bit_idx <= 4'(RES_W - 1);
              sar_q   <= '0;
            end else begin
              smp_cnt <= smp_cnt + 1'b1;
            end
          end
          CONV: if (conv_tick) begin
            sar_q <= decided;
            if (finish) begin
              state   <= sc_cont ? SAMPLE : IDLE;
              smp_cnt <= '0;
            end else begin
              bit_idx <= bit_idx - 4'd1;
            end
          end
          default: state <= IDLE;
        endcase
      end
    end
  end

  // R13
  deep_stop_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_mode[1] |=> (state == IDLE && !done_q && !res_lock && cfg_src == 2'd0 && !sc_en));

  // R12
  light_halt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (light && cfg_src != 2'd3) |=> (state == IDLE));

  // R9
  lock_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (res_lock && !pwr_mode[1]) |=> $stable(res_q));

  // R9
  flag_needs_unlock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_q) |-> !$past(res_lock));

  // R3
  conv_after_sample_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == CONV && $past(state) != CONV) |-> ($past(state) == SAMPLE));

  // R11
  irq_needs_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> ($past(finish) || $past(sc_wr)));
endmodule

// File: tb/tb_adc_sar_ctrl.sv
`timescale 1ns/1ps
module tb_adc_sar_ctrl;
  logic       clk = 1'b0, rst_n = 1'b0;
  logic [1:0] pwr_mode = 2'd0;
  logic       alt_tick = 1'b0, async_tick = 1'b0;
  logic [1:0] reg_addr = 2'd0;
  logic       wr_en = 1'b0, rd_en = 1'b0, hw_trig = 1'b0;
  logic [7:0] wr_data = 8'd0;
  logic [7:0] rd_data;
  logic [9:0] dac_code;
  logic       sampling, irq, cmp_in;
  logic [9:0] vin = 10'd0;
  int n_chk = 0, n_fail = 0;
  int tcnt = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;
  assign cmp_in = (vin >= dac_code);

  always @(posedge clk) begin
    tcnt <= (tcnt == 2) ? 0 : tcnt + 1;
    async_tick <= (tcnt == 2);
  end

  adc_sar_ctrl dut (
    .clk(clk), .rst_n(rst_n), .pwr_mode(pwr_mode), .alt_tick(alt_tick),
    .async_tick(async_tick), .reg_addr(reg_addr), .wr_en(wr_en), .wr_data(wr_data),
    .rd_en(rd_en), .rd_data(rd_data), .hw_trig(hw_trig), .cmp_in(cmp_in),
    .dac_code(dac_code), .sampling(sampling), .irq(irq));

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d (0x%0h) expected %0d (0x%0h)", req, act, act, exp, exp);
    end
  endtask

  task automatic chk_range(input string req, input int act, input int lo, input int hi);
    n_chk++;
    if (act < lo || act > hi) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d..%0d", req, act, lo, hi);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); reg_addr = a; wr_data = d; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); reg_addr = a; rd_en = 1'b1; #1 d = rd_data;
    @(negedge clk); rd_en = 1'b0;
  endtask

  task automatic peek(input logic [1:0] a, output logic [7:0] d);
    reg_addr = a; rd_en = 1'b0; #1 d = rd_data;
  endtask

  task automatic wait_done(input int maxc, output int n);
    logic [7:0] d;
    n = maxc + 1;
    for (int i = 1; i <= maxc; i++) begin
      @(negedge clk); peek(2'd1, d);
      if (d[7]) begin n = i; break; end
    end
  endtask

  task automatic idle_clean();
    logic [7:0] d;
    wr(2'd1, 8'h00);
    rd(2'd3, d);
  endtask

  task automatic t_reset();
    logic [7:0] d;
    peek(2'd0, d); chk("R1 cfg", d, 0);
    peek(2'd1, d); chk("R1 ctrl", d, 0);
    peek(2'd2, d); chk("R1 res hi", d, 0);
    peek(2'd3, d); chk("R1 res lo", d, 0);
    chk("R1 irq", irq, 0);
  endtask

  task automatic t_cfg();
    logic [7:0] d;
    wr(2'd0, 8'h6B); peek(2'd0, d); chk("R2 readback", d, 8'h6B);
    wr(2'd0, 8'h14); peek(2'd0, d); chk("R2 readback 2", d, 8'h14);
  endtask

  task automatic t_single10();
    logic [7:0] d; int n;
    wr(2'd0, 8'h20); vin = 10'h2A5;
    wr(2'd1, 8'h01); wait_done(100, n);
    chk("R3 latency 10-bit", n, 14);
    chk("R8 irq off when ie=0", irq, 0);
    rd(2'd2, d); chk("R4 hi 10-bit", d, 8'h02);
    rd(2'd3, d); chk("R4 lo 10-bit", d, 8'hA5);
    peek(2'd1, d); chk("R8 done cleared by low read", d[7], 0);
  endtask

  task automatic t_single8();
    logic [7:0] d; int n;
    wr(2'd0, 8'h00); vin = 10'h2A5;
    wr(2'd1, 8'h01); wait_done(100, n);
    chk("R3 latency 8-bit", n, 12);
    rd(2'd2, d); chk("R4 hi 8-bit", d, 0);
    rd(2'd3, d); chk("R4 lo 8-bit", d, 8'hA9);
  endtask

  task automatic t_long_div();
    int n;
    wr(2'd0, 8'h30); vin = 10'h3FF;
    wr(2'd1, 8'h01); wait_done(100, n);
    chk("R3 latency long sample", n, 30);
    idle_clean();
    wr(2'd0, 8'h2C);
    wr(2'd1, 8'h01); wait_done(300, n);
    chk_range("R5 latency divide by 8", n, 105, 112);
    idle_clean();
  endtask

  task automatic t_irq();
    logic [7:0] d; int n;
    wr(2'd0, 8'h20); vin = 10'h011;
    wr(2'd1, 8'h41);
    chk("R8 irq low while converting", irq, 0);
    wait_done(100, n);
    chk("R8 irq on done with ie", irq, 1);
    wr(2'd1, 8'h40); peek(2'd1, d);
    chk("R8 ctrl write clears done", d[7], 0);
    chk("R8 irq cleared", irq, 0);
    idle_clean();
  endtask

  task automatic t_trigger();
    logic [7:0] d; int n;
    wr(2'd0, 8'h20); vin = 10'h1C3;
    wr(2'd1, 8'h11); wait_done(40, n);
    chk("R6 no start without trigger", n, 41);
    @(negedge clk); hw_trig = 1'b1; @(negedge clk); hw_trig = 1'b0;
    wait_done(100, n);
    chk_range("R6 trigger starts", n, 1, 14);
    rd(2'd2, d); rd(2'd3, d); chk("R6 trigger result", d, 8'hC3);
    wr(2'd1, 8'h00); wait_done(40, n);
    chk("R6 enable=0 never starts", n, 41);
  endtask

  task automatic t_lock();
    logic [7:0] d; int n;
    wr(2'd0, 8'h20); vin = 10'h155;
    wr(2'd1, 8'h01); wait_done(100, n);
    rd(2'd2, d); chk("R9 hi before lock", d, 8'h01);
    vin = 10'h0F0;
    wr(2'd1, 8'h01); wait_done(60, n);
    chk("R9 flag blocked by lock", n, 61);
    rd(2'd3, d); chk("R9 result held by lock", d, 8'h55);
    wr(2'd1, 8'h01); wait_done(100, n);
    rd(2'd2, d); rd(2'd3, d); chk("R9 update after unlock", d, 8'hF0);
  endtask

  task automatic t_cont();
    logic [7:0] d; int n;
    wr(2'd0, 8'h20); vin = 10'h100;
    wr(2'd1, 8'h21); wait_done(100, n);
    rd(2'd2, d); chk("R7 first hi", d, 8'h01);
    rd(2'd3, d); chk("R7 first lo", d, 8'h00);
    vin = 10'h3FF;
    wait_done(100, n); rd(2'd2, d); rd(2'd3, d);
    wait_done(100, n);
    chk_range("R7 repeats without write", n, 1, 14);
    rd(2'd2, d); chk("R7 later hi", d, 8'h03);
    rd(2'd3, d); chk("R7 later lo", d, 8'hFF);
    idle_clean();
  endtask

  task automatic t_abort();
    int n;
    wr(2'd0, 8'h20); vin = 10'h0AA;
    wr(2'd1, 8'h01);
    repeat (6) @(negedge clk);
    wr(2'd1, 8'h01); wait_done(100, n);
    chk("R10 restart latency", n, 14);
    idle_clean();
  endtask

  task automatic t_light_async();
    logic [7:0] d; int n;
    wr(2'd0, 8'h23); vin = 10'h2F0;
    wr(2'd1, 8'h41);
    repeat (3) @(negedge clk); pwr_mode = 2'd1;
    wait_done(200, n);
    chk_range("R11 completes in light stop", n, 1, 200);
    chk("R11 wake irq", irq, 1);
    rd(2'd2, d); rd(2'd3, d); chk("R11 result", d, 8'hF0);
    wr(2'd1, 8'h51); wait_done(30, n);
    chk("R11 idle until trigger", n, 31);
    @(negedge clk); hw_trig = 1'b1; @(negedge clk); hw_trig = 1'b0;
    wait_done(200, n);
    chk_range("R11 trigger in light stop", n, 1, 200);
    pwr_mode = 2'd0;
    idle_clean();
  endtask

  task automatic t_light_sync();
    int n;
    wr(2'd0, 8'h20); vin = 10'h123;
    wr(2'd1, 8'h41);
    repeat (5) @(negedge clk); pwr_mode = 2'd1;
    wait_done(60, n);
    chk("R12 conversion abandoned", n, 61);
    chk("R12 no irq", irq, 0);
    wr(2'd1, 8'h01); wait_done(40, n);
    chk("R12 no software start", n, 41);
    wr(2'd1, 8'h51);
    @(negedge clk); hw_trig = 1'b1; @(negedge clk); hw_trig = 1'b0;
    wait_done(60, n);
    chk("R12 trigger ignored", n, 61);
    pwr_mode = 2'd0;
    wait_done(30, n);
    chk("R12 no resume after wake", n, 31);
    idle_clean();
  endtask

  task automatic t_deep();
    logic [7:0] d; int n;
    wr(2'd0, 8'h6B); vin = 10'h200;
    wr(2'd1, 8'h61);
    repeat (4) @(negedge clk); pwr_mode = 2'd2;
    repeat (2) @(negedge clk); pwr_mode = 2'd0;
    peek(2'd0, d); chk("R13 cfg reset", d, 0);
    peek(2'd1, d); chk("R13 ctrl reset", d, 0);
    wait_done(60, n);
    chk("R13 stays idle", n, 61);
    peek(2'd3, d); chk("R13 result reset", d, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_cfg();
    t_single10();
    t_single8();
    t_long_div();
    t_irq();
    t_trigger();
    t_lock();
    t_cont();
    t_abort();
    t_light_async();
    t_light_sync();
    t_deep();
    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    #(20 * 150000);
    if (!finished) begin
      finished = 1'b1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule